// File: doc/BRIEF.md
# Time-Slotted Transmit Arbiter for a Shared CAN Port

This block decides which of several client transmit queues may start the next CAN frame on one shared gateway port. Each client owns a slot that lasts one CAN bit period. The slots are visited in a rotation. On every bit-period strobe that arrives while the bus is idle, the arbiter looks at the single client that owns the current slot. If that client's queue holds a message, the arbiter issues a one-cycle start pulse to the frame transmitter, together with the client number and its message ID. The slot pointer then moves on to the next client.

The rotation order is not the client index. Clients are ranked by the CAN ID each one presents, lowest ID first, and equal IDs are ranked by lower client index. Slot k belongs to the client of rank k. While a frame is on the bus, the bus-idle input is low and the rotation pauses. A client that misses its slot must therefore wait at most one full rotation of idle bit periods. The queues and the frame transmitter are outside this block.

Top module: `tx_slot_arbiter`

## Requirements
- R1: After reset, start_o is 0, grant_vec_o is all zero, grant_idx_o and grant_id_o are 0, and the slot pointer is at rank 0, so the first idle strobe serves the client with the lowest rank.
- R2: start_o is high only in the cycle that directly follows a cycle in which bit_tick_i and bus_idle_i were both 1, and it is high for exactly one cycle.
- R3: A strobe that arrives while bus_idle_i is 0 produces no start pulse, leaves the grant outputs unchanged and does not move the slot pointer.
- R4: Slot k is owned by the client whose rank is k. A client's rank is the number of other clients whose ID is smaller than its own, plus the number of lower-index clients whose ID is equal to its own.
- R5: When the owner of the current slot has q_nonempty_i set at an idle strobe, start_o rises in the next cycle. In that same cycle grant_idx_o shows the owner's index, grant_vec_o has only that index's bit set, and grant_id_o shows that client's ID as it was sampled at the strobe.
- R6: When the owner of the current slot has an empty queue at an idle strobe, no start pulse is issued and grant_vec_o, grant_idx_o and grant_id_o keep their previous values.
- R7: Every idle strobe moves the slot pointer forward by one rank, whether or not a grant is issued. After rank N_CLIENTS-1 the pointer wraps back to rank 0.
- R8: grant_vec_o is either all zero (before the first grant) or one-hot, and when it is one-hot its set bit is the one at position grant_idx_o.
- R9: If the IDs stay stable, a client whose queue stays non-empty is granted within N_CLIENTS idle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick_i | input | 1 | One-cycle strobe at the start of each CAN bit period. Strobes are at least two cycles apart. |
| bus_idle_i | input | 1 | High while no frame is on the bus |
| q_nonempty_i | input | N_CLIENTS | Per-client flag: the client's transmit queue holds a message |
| q_id_i | input | N_CLIENTS*ID_W | Per-client CAN ID. Client c occupies bits [c*ID_W +: ID_W]. |
| start_o | output | 1 | One-cycle pulse that tells the transmitter to start a frame |
| grant_vec_o | output | N_CLIENTS | One-hot copy of the last granted client |
| grant_idx_o | output | IDX_W | Index of the last granted client |
| grant_id_o | output | ID_W | CAN ID of the last granted message |

## Verification
The bound checker covers the behaviours that can be seen in every cycle:
- a start pulse appears only after an idle strobe and never after a busy one;
- the start pulse is one cycle wide;
- the grant outputs hold still whenever there is no start pulse;
- the grant vector is one-hot and agrees with the grant index;
- a granted client had a pending message at the strobe.

The ID-ranked rotation order, the tie-break by client index, the wrap of the slot pointer, the pause while the bus is busy, and the bound of one full rotation all depend on a history of several strobes. Only the bench's scenarios can show them. The bench checks them against its own ranking and slot model, using randomised IDs, occupancy and bus activity, and it adds directed cases for equal IDs and for a single waiting client.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Index width that stays at least one bit for a single client.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_rank_order.sv
// Ranks clients by CAN ID (ties broken by lower index) and finds the owner
// of the given slot rank.
module rr_rank_order #(
  parameter int N_CLIENTS = 6,
  parameter int ID_W      = 11,
  localparam int IDX_W    = arb_pkg::idx_width(N_CLIENTS),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic [N_CLIENTS*ID_W-1:0] ids_i,
  input  logic [IDX_W-1:0]          slot_i,
  output logic [N_CLIENTS-1:0]      owner_vec_o,
  output logic [IDX_W-1:0]          owner_idx_o
);

  logic [ID_W-1:0] id_arr [N_CLIENTS];

  for (genvar k = 0; k < N_CLIENTS; k++) begin : g_unpack
    assign id_arr[k] = ids_i[k*ID_W +: ID_W];
  end

  for (genvar i = 0; i < N_CLIENTS; i++) begin : g_rank
    logic [CNT_W-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < N_CLIENTS; j++) begin
        if (j != i) begin
          if ((id_arr[j] < id_arr[i]) || ((id_arr[j] == id_arr[i]) && (j < i)))
            rank = rank + CNT_W'(1);
        end
      end
    end
    assign owner_vec_o[i] = (rank == {1'b0, slot_i});
  end

  always_comb begin
    owner_idx_o = '0;
    for (int k = 0; k < N_CLIENTS; k++) begin
      if (owner_vec_o[k]) owner_idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/rr_slot_ptr.sv
// Slot pointer: moves one rank per idle bit strobe and wraps.
module rr_slot_ptr #(
  parameter int N_CLIENTS = 6,
  localparam int IDX_W    = arb_pkg::idx_width(N_CLIENTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [IDX_W-1:0] slot_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CLIENTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o <= '0;
    end else if (adv_i) begin
      slot_o <= (slot_o == LAST) ? '0 : slot_o + IDX_W'(1);
    end
  end

endmodule

// File: rtl/rr_grant_reg.sv
// Registered grant outputs and start pulse.
module rr_grant_reg #(
  parameter int N_CLIENTS = 6,
  parameter int ID_W      = 11,
  localparam int IDX_W    = arb_pkg::idx_width(N_CLIENTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire_i,
  input  logic                 pend_i,
  input  logic [N_CLIENTS-1:0] owner_vec_i,
  input  logic [IDX_W-1:0]     owner_idx_i,
  input  logic [ID_W-1:0]      owner_id_i,
  output logic                 start_o,
  output logic [N_CLIENTS-1:0] grant_vec_o,
  output logic [IDX_W-1:0]     grant_idx_o,
  output logic [ID_W-1:0]      grant_id_o
);

  logic take;
  assign take = fire_i & pend_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o     <= 1'b0;
      grant_vec_o <= '0;
      grant_idx_o <= '0;
      grant_id_o  <= '0;
    end else begin
      start_o <= take;
      if (take) begin
        grant_vec_o <= owner_vec_i;
        grant_idx_o <= owner_idx_i;
        grant_id_o  <= owner_id_i;
      end
    end
  end

endmodule

// File: rtl/tx_slot_arbiter.sv
// Time-slotted, ID-ordered transmit arbiter for a shared CAN port.
module tx_slot_arbiter #(
  parameter int N_CLIENTS = 6,
  parameter int ID_W      = 11,
  localparam int IDX_W    = arb_pkg::idx_width(N_CLIENTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bit_tick_i,
  input  logic                      bus_idle_i,
  input  logic [N_CLIENTS-1:0]      q_nonempty_i,
  input  logic [N_CLIENTS*ID_W-1:0] q_id_i,
  output logic                      start_o,
  output logic [N_CLIENTS-1:0]      grant_vec_o,
  output logic [IDX_W-1:0]          grant_idx_o,
  output logic [ID_W-1:0]           grant_id_o
);

  logic [IDX_W-1:0]     slot;
  logic [N_CLIENTS-1:0] owner_vec;
  logic [IDX_W-1:0]     owner_idx;
  logic [ID_W-1:0]      owner_id;
  logic                 fire;
  logic                 pend;

  // A slot is evaluated only at a bit-period start while the bus is free.
  assign fire = bit_tick_i & bus_idle_i;
  assign pend = |(owner_vec & q_nonempty_i);

  always_comb begin
    owner_id = '0;
    for (int k = 0; k < N_CLIENTS; k++) begin
      if (owner_vec[k]) owner_id = q_id_i[k*ID_W +: ID_W];
    end
  end

  rr_rank_order #(.N_CLIENTS(N_CLIENTS), .ID_W(ID_W)) u_rank (
    .ids_i       (q_id_i),
    .slot_i      (slot),
    .owner_vec_o (owner_vec),
    .owner_idx_o (owner_idx)
  );

  rr_slot_ptr #(.N_CLIENTS(N_CLIENTS)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (fire),
    .slot_o (slot)
  );

  rr_grant_reg #(.N_CLIENTS(N_CLIENTS), .ID_W(ID_W)) u_grant (
    .clk         (clk),
    .rst         (rst),
    .fire_i      (fire),
    .pend_i      (pend),
    .owner_vec_i (owner_vec),
    .owner_idx_i (owner_idx),
    .owner_id_i  (owner_id),
    .start_o     (start_o),
    .grant_vec_o (grant_vec_o),
    .grant_idx_o (grant_idx_o),
    .grant_id_o  (grant_id_o)
  );

endmodule

// File: rtl/tx_slot_arbiter_chk.sv
module tx_slot_arbiter_chk #(
  parameter int N_CLIENTS = 6,
  parameter int ID_W      = 11,
  localparam int IDX_W    = arb_pkg::idx_width(N_CLIENTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bit_tick_i,
  input logic                 bus_idle_i,
  input logic [N_CLIENTS-1:0] q_nonempty_i,
  input logic                 start_o,
  input logic [N_CLIENTS-1:0] grant_vec_o,
  input logic [IDX_W-1:0]     grant_idx_o
);

  logic                 idle_tick_q;
  logic                 busy_tick_q;
  logic [N_CLIENTS-1:0] ne_q;

  always_ff @(posedge clk) begin
    idle_tick_q <= bit_tick_i & bus_idle_i;
    busy_tick_q <= bit_tick_i & ~bus_idle_i;
    ne_q        <= q_nonempty_i;
  end

  p_start_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
    start_o |-> idle_tick_q);

  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  p_busy_no_start_r3: assert property (@(posedge clk) disable iff (rst)
    busy_tick_q |-> !start_o);

  p_start_pending_r5: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ne_q[grant_idx_o]);

  p_hold_grant_r6: assert property (@(posedge clk) disable iff (rst)
    !start_o |-> ($stable(grant_idx_o) && $stable(grant_vec_o)));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec_o));

  p_vec_matches_idx_r8: assert property (@(posedge clk) disable iff (rst)
    (grant_vec_o != '0) |-> grant_vec_o[grant_idx_o]);

endmodule

bind tx_slot_arbiter tx_slot_arbiter_chk #(.N_CLIENTS(N_CLIENTS), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_tick_i   (bit_tick_i),
  .bus_idle_i   (bus_idle_i),
  .q_nonempty_i (q_nonempty_i),
  .start_o      (start_o),
  .grant_vec_o  (grant_vec_o),
  .grant_idx_o  (grant_idx_o)
);

// File: tb/tb_tx_slot_arbiter.sv
`timescale 1ns/100ps
module tb_tx_slot_arbiter;

  localparam int N     = 6;
  localparam int ID_W  = 11;
  localparam int IDX_W = arb_pkg::idx_width(N);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 bit_tick = 1'b0;
  logic                 bus_idle = 1'b1;
  logic [N-1:0]         nonempty = '0;
  logic [N*ID_W-1:0]    id_flat = '0;
  logic                 start_o;
  logic [N-1:0]         grant_vec_o;
  logic [IDX_W-1:0]     grant_idx_o;
  logic [ID_W-1:0]      grant_id_o;

  logic [ID_W-1:0] ids [N];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state.
  int        m_slot = 0;
  bit        m_valid = 1'b0;
  int        m_idx = 0;
  logic [ID_W-1:0] m_id = '0;

  always #2.5 clk = ~clk;

  tx_slot_arbiter #(.N_CLIENTS(N), .ID_W(ID_W)) dut (
    .clk          (clk),
    .rst          (rst),
    .bit_tick_i   (bit_tick),
    .bus_idle_i   (bus_idle),
    .q_nonempty_i (nonempty),
    .q_id_i       (id_flat),
    .start_o      (start_o),
    .grant_vec_o  (grant_vec_o),
    .grant_idx_o  (grant_idx_o),
    .grant_id_o   (grant_id_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Owner of a slot: client whose ID rank equals the slot (R4).
  function automatic int owner_of(input int slot);
    for (int i = 0; i < N; i++) begin
      int r = 0;
      for (int j = 0; j < N; j++)
        if (j != i && (ids[j] < ids[i] || (ids[j] == ids[i] && j < i))) r++;
      if (r == slot) return i;
    end
    return 0;
  endfunction

  task automatic pack_ids();
    for (int k = 0; k < N; k++) id_flat[k*ID_W +: ID_W] = ids[k];
  endtask

  // One bit-period strobe; got reports whether a start pulse was seen.
  task automatic strobe(input bit idle, input string req, output bit got);
    bit exp_hit;
    exp_hit = 1'b0;
    @(negedge clk);
    pack_ids();
    bus_idle = idle;
    bit_tick = 1'b1;
    if (idle) begin
      int c;
      c = owner_of(m_slot);
      exp_hit = nonempty[c];
      if (exp_hit) begin
        m_valid = 1'b1;
        m_idx = c;
        m_id = ids[c];
      end
      m_slot = (m_slot + 1) % N;
    end
    @(negedge clk);
    bit_tick = 1'b0;
    got = start_o;
    chk(start_o == exp_hit, req, "start_o", start_o, exp_hit);
    if (m_valid) begin
      chk(grant_idx_o == IDX_W'(m_idx), req, "grant_idx_o", grant_idx_o, m_idx);
      chk(grant_id_o == m_id, req, "grant_id_o", grant_id_o, m_id);
      chk(grant_vec_o == N'(1 << m_idx), "R8", "grant_vec_o", grant_vec_o, 1 << m_idx);
    end else begin
      chk(grant_vec_o == '0, req, "grant_vec_o idle", grant_vec_o, 0);
    end
    @(negedge clk);
    chk(start_o == 1'b0, "R2", "start_o width", start_o, 0);
    bus_idle = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit got;
    void'($urandom(32'd2024));
    for (int k = 0; k < N; k++) ids[k] = ID_W'(100 - 10 * k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(start_o == 1'b0, "R1", "start_o", start_o, 0);
    chk(grant_vec_o == '0, "R1", "grant_vec_o", grant_vec_o, 0);
    chk(grant_idx_o == '0, "R1", "grant_idx_o", grant_idx_o, 0);
    chk(grant_id_o == '0, "R1", "grant_id_o", grant_id_o, 0);

    // R1/R4: first idle strobe serves lowest ID (client N-1 here)
    nonempty = '1;
    strobe(1'b1, "R1", got);
    chk(got && grant_idx_o == IDX_W'(N - 1), "R4", "lowest id first", grant_idx_o, N - 1);

    // R3: busy strobes neither grant nor advance
    strobe(1'b0, "R3", got);
    strobe(1'b0, "R3", got);
    strobe(1'b1, "R3", got);
    chk(grant_idx_o == IDX_W'(N - 2), "R3", "pointer held", grant_idx_o, N - 2);

    // R4/R7: equal IDs -> index order, with wrap
    for (int k = 0; k < N; k++) ids[k] = ID_W'(5);
    while (m_slot != 0) strobe(1'b1, "R7", got);
    for (int k = 0; k < N + 1; k++) begin
      strobe(1'b1, "R4", got);
      chk(grant_idx_o == IDX_W'(k % N), "R7", "tie order/wrap", grant_idx_o, k % N);
    end

    // R6: empty owner -> no grant, outputs hold
    nonempty = '0;
    for (int k = 0; k < N; k++) strobe(1'b1, "R6", got);

    // R9: single waiting client served within N idle strobes
    for (int t = 0; t < N; t++) begin
      int waited;
      for (int k = 0; k < N; k++) ids[k] = ID_W'(k * 37 + t * 3);
      nonempty = '0;
      nonempty[t] = 1'b1;
      waited = 0;
      got = 1'b0;
      while (!got && waited <= N) begin
        strobe(($urandom_range(0, 3) != 0), "R9", got);
        if (bus_idle) waited++;
        if (bit_tick == 1'b0 && got) break;
      end
      chk(got, "R9", "served within rotation", got, 1);
    end

    // R5: random mix
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < N; k++)
        ids[k] = ($urandom_range(0, 1) != 0) ? ID_W'($urandom_range(0, 7))
                                              : ID_W'($urandom);
      nonempty = N'($urandom);
      strobe(($urandom_range(0, 3) != 0), "R5", got);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule